// File: doc/BRIEF.md
# Page table address translator

This block turns a logical address into a physical address using a single-level page table kept in main memory. The logical address is cut into a page number (upper bits) and an in-page offset (lower bits). Because pages are a power of two in size, the offset is carried through untouched. The frame number comes from the table entry and is placed directly above the offset, so no adder sits on the data path.

Two configuration inputs describe the table. A base input gives the byte address of entry 0. A length input gives how many entries are valid. For each in-range request the block issues exactly one read to memory, at the entry for that page, and waits for the frame number. A page number at or beyond the length produces a fault response without touching memory.

Requests, table reads and responses each use a valid/ready handshake. One translation is handled at a time.

Top module: `pt_xlate`

## Requirements
- R1: While reset is asserted and after it is released, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0 until a request arrives.
- R2: The page number is the top LADDR_W-OFF_W bits of `req_laddr` and the offset is its low OFF_W bits. A successful response has `rsp_paddr` = {frame, offset} with `rsp_fault` = 0. With defaults, logical 0x05DE whose page 1 maps to frame 3 gives 0x0DDE.
- R3: The table read goes to address `ptbr` + page × ENTRY_BYTES (default 2). The frame is taken from `mem_rsp_frame`.
- R4: Every in-range translation issues exactly one table read, and it does so before its response appears.
- R5: A page number greater than or equal to `ptlr` gives `rsp_fault` = 1 with `rsp_paddr` = 0 and issues no table read.
- R6: The last entry, page = `ptlr` − 1, is in range and translates normally.
- R7: From acceptance of a request until its response is taken, `req_ready` stays 0.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid and `rsp_paddr`/`rsp_fault` stay unchanged.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the read request stays valid with an unchanged address.
- R10: With `ptlr` = 0 every request faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ptbr | input | MADDR_W | Byte address of page table entry 0 |
| ptlr | input | LADDR_W-OFF_W+1 | Number of valid table entries |
| req_valid | input | 1 | Logical address offered |
| req_ready | output | 1 | Translator idle and accepting |
| req_laddr | input | LADDR_W | Logical address |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page number out of table range |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | MADDR_W | Byte address of table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_frame | input | FRAME_W | Frame number read from table |

## Verification
The translation is tried with offsets of all-zero, all-one and mixed bit patterns on several pages. This separates a correct concatenation from a swapped, shifted or added join. Two different table base addresses and several page numbers expose a wrong entry stride or base. Pages at length−1, at length and far above it, plus a zero length, pin down the bound comparison and confirm that faults leave the read count unchanged. Back-pressure on the read port and on the response port shows whether the held request, held result and single-flight rule survive stalls.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } pt_state_e;
endpackage

// File: rtl/pt_addr_split.sv
module pt_addr_split #(
  parameter int LADDR_W     = 16,
  parameter int OFF_W       = 10,
  parameter int MADDR_W     = 16,
  parameter int ENTRY_BYTES = 2,
  localparam int PN_W       = LADDR_W - OFF_W
) (
  input  logic [LADDR_W-1:0] laddr,
  input  logic [MADDR_W-1:0] tbl_base,
  input  logic [PN_W:0]      tbl_len,
  output logic [OFF_W-1:0]   offset,
  output logic               in_range,
  output logic [MADDR_W-1:0] tbl_addr
);
  logic [PN_W-1:0] page;

  always_comb begin
    page     = laddr[LADDR_W-1:OFF_W];
    offset   = laddr[OFF_W-1:0];
    in_range = ({1'b0, page} < tbl_len);
    tbl_addr = tbl_base + (MADDR_W'(page) * MADDR_W'(ENTRY_BYTES));
  end
endmodule

// File: rtl/pt_join.sv
module pt_join #(
  parameter int FRAME_W = 6,
  parameter int OFF_W   = 10,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic [FRAME_W-1:0] frame,
  input  logic [OFF_W-1:0]   offset,
  input  logic               fault,
  output logic [PA_W-1:0]    paddr
);
  always_comb begin
    if (fault) paddr = '0;
    else       paddr = {frame, offset};
  end
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pt_pkg::*;
#(
  parameter int OFF_W   = 10,
  parameter int FRAME_W = 6,
  parameter int MADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [OFF_W-1:0]   in_offset,
  input  logic               in_range,
  input  logic [MADDR_W-1:0] in_tbl_addr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [MADDR_W-1:0] mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [FRAME_W-1:0] mem_rsp_frame,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [FRAME_W-1:0] frame_q,
  output logic [OFF_W-1:0]   off_q,
  output logic               fault_q
);
  pt_state_e            state_q, state_d;
  logic [MADDR_W-1:0]   tbl_q;
  logic                 cap_en, frm_en;

  // next-state and output decode
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid)     state_d = in_range ? ST_READ : ST_RESP;
      ST_READ: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) state_d = ST_RESP;
      ST_RESP: if (rsp_ready)     state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    mem_req_valid = (state_q == ST_READ);
    rsp_valid     = (state_q == ST_RESP);
    mem_req_addr  = tbl_q;
    cap_en        = req_ready & req_valid;
    frm_en        = (state_q == ST_WAIT) & mem_rsp_valid;
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // data registers, enable only
  always_ff @(posedge clk) begin
    if (cap_en) begin
      off_q   <= in_offset;
      tbl_q   <= in_tbl_addr;
      fault_q <= ~in_range;
    end
  end

  always_ff @(posedge clk) begin
    if (frm_en) frame_q <= mem_rsp_frame;
  end

  AST_ACCEPT_ISSUES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && in_range) |=> mem_req_valid); // R4
  AST_FAULT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !fault_q); // R5
  AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(off_q) && $stable(fault_q) && $stable(frame_q))); // R8
  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int LADDR_W     = 16,
  parameter int OFF_W       = 10,
  parameter int FRAME_W     = 6,
  parameter int MADDR_W     = 16,
  parameter int ENTRY_BYTES = 2,
  localparam int PN_W       = LADDR_W - OFF_W,
  localparam int PA_W       = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MADDR_W-1:0] ptbr,
  input  logic [PN_W:0]      ptlr,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LADDR_W-1:0] req_laddr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               rsp_fault,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [MADDR_W-1:0] mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [FRAME_W-1:0] mem_rsp_frame
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  logic [OFF_W-1:0]   sp_offset, off_q;
  logic               sp_in_range, fault_q;
  logic [MADDR_W-1:0] sp_tbl_addr;
  logic [FRAME_W-1:0] frame_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  pt_addr_split #(
    .LADDR_W(LADDR_W), .OFF_W(OFF_W), .MADDR_W(MADDR_W), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_split (
    .laddr(req_laddr), .tbl_base(ptbr), .tbl_len(ptlr),
    .offset(sp_offset), .in_range(sp_in_range), .tbl_addr(sp_tbl_addr)
  );

  pt_ctrl #(
    .OFF_W(OFF_W), .FRAME_W(FRAME_W), .MADDR_W(MADDR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n_int),
    .req_valid(req_valid), .req_ready(req_ready),
    .in_offset(sp_offset), .in_range(sp_in_range), .in_tbl_addr(sp_tbl_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_frame(mem_rsp_frame),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .frame_q(frame_q), .off_q(off_q), .fault_q(fault_q)
  );

  pt_join #(.FRAME_W(FRAME_W), .OFF_W(OFF_W)) u_join (
    .frame(frame_q), .offset(off_q), .fault(fault_q), .paddr(rsp_paddr)
  );

  assign rsp_fault = fault_q;

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R5
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(rst_n_int) |-> (req_ready && !rsp_valid && !mem_req_valid)); // R1
endmodule

// File: tb/pt_xlate_tb.sv
`timescale 1ns/1ps
module pt_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ptbr;
  logic [6:0]  ptlr;
  logic        req_valid, req_ready, rsp_valid, rsp_ready, rsp_fault;
  logic [15:0] req_laddr, rsp_paddr, mem_req_addr;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [5:0]  mem_rsp_frame;

  int errors = 0;
  int checks = 0;
  int reads  = 0;
  logic [15:0] last_addr;
  logic [5:0]  mem [0:1023];
  logic [16:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  pt_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .ptbr(ptbr), .ptlr(ptlr),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_frame(mem_rsp_frame)
  );

  // memory model: one-cycle read latency, entries 2 bytes wide
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_frame <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_frame <= mem[mem_req_addr[10:1]];
        reads         <= reads + 1;
        last_addr     <= mem_req_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected response", {15'd0, rsp_fault, rsp_paddr}, 32'd0);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({rsp_fault, rsp_paddr} === e, t, {15'd0, rsp_fault, rsp_paddr}, {15'd0, e});
      end
    end
  end

  task automatic send(input logic [15:0] la, input logic [15:0] epa, input logic ef, input string tag);
    exp_q.push_back({ef, epa});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_laddr = la;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic xlate(input logic [15:0] la, input logic [15:0] epa, input logic ef, input string tag);
    send(la, epa, ef, tag);
    drain();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r0;
    logic [15:0] held;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    // table A at 0x0100: page0->5, page1->3, page2->0x2A
    mem[16'h0100 >> 1]       = 6'd5;
    mem[(16'h0100 >> 1) + 1] = 6'd3;
    mem[(16'h0100 >> 1) + 2] = 6'h2A;
    // table B at 0x0200: page0->0x11, page5->0x3F
    mem[16'h0200 >> 1]       = 6'h11;
    mem[(16'h0200 >> 1) + 5] = 6'h3F;

    rst_n = 1'b0; req_valid = 1'b0; req_laddr = '0; rsp_ready = 1'b1;
    mem_req_ready = 1'b1; ptbr = 16'h0100; ptlr = 7'd3;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
        {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 idle after release",
        {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

    // R2 worked example and R3 address, R4 single read
    r0 = reads;
    xlate(16'h05DE, 16'h0DDE, 1'b0, "R2 page1 0x05DE");
    chk(last_addr == 16'h0102, "R3 table address page1", {16'd0, last_addr}, 32'h0102);
    chk(reads == r0 + 1, "R4 one read per translation", reads, r0 + 1);

    xlate(16'h03FF, {6'd5, 10'h3FF}, 1'b0, "R2 page0 offset all ones");
    chk(last_addr == 16'h0100, "R3 table address page0", {16'd0, last_addr}, 32'h0100);
    xlate(16'h0803, {6'h2A, 10'h003}, 1'b0, "R6 last entry page2");
    chk(last_addr == 16'h0104, "R3 table address page2", {16'd0, last_addr}, 32'h0104);

    // R5 out of range
    r0 = reads;
    xlate(16'h0C55, 16'h0000, 1'b1, "R5 page equals length");
    xlate(16'hFFFF, 16'h0000, 1'b1, "R5 page 63");
    chk(reads == r0, "R5 no table read on fault", reads, r0);

    // R10 zero length
    ptlr = 7'd0;
    r0 = reads;
    xlate(16'h0001, 16'h0000, 1'b1, "R10 zero length faults page0");
    chk(reads == r0, "R10 no read with zero length", reads, r0);

    // second table, other base
    ptbr = 16'h0200; ptlr = 7'd64;
    xlate(16'h1555, {6'h3F, 10'h155}, 1'b0, "R2 table B page5");
    chk(last_addr == 16'h020A, "R3 table address base B page5", {16'd0, last_addr}, 32'h020A);
    xlate(16'h02AA, {6'h11, 10'h2AA}, 1'b0, "R2 table B page0");

    // R9 read stall
    mem_req_ready = 1'b0;
    send(16'h1400, {6'h3F, 10'h000}, 1'b0, "R9 result after read stall");
    while (!mem_req_valid) @(negedge clk);
    held = mem_req_addr;
    repeat (3) @(negedge clk);
    chk(mem_req_valid && mem_req_addr == held, "R9 read request held",
        {15'd0, mem_req_valid, mem_req_addr}, {15'd1, held});
    chk(!rsp_valid, "R4 no response before read", {31'd0, rsp_valid}, 32'd0);
    chk(!req_ready, "R7 busy during read", {31'd0, req_ready}, 32'd0);
    mem_req_ready = 1'b1;
    drain();

    // R8 response stall
    rsp_ready = 1'b0;
    send(16'h03C3, {6'h11, 10'h3C3}, 1'b0, "R8 result after response stall");
    while (!rsp_valid) @(negedge clk);
    held = rsp_paddr;
    repeat (4) @(negedge clk);
    chk(rsp_valid && rsp_paddr == held, "R8 response held",
        {15'd0, rsp_valid, rsp_paddr}, {15'd1, held});
    chk(!req_ready, "R7 busy while response pending", {31'd0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    drain();
    @(negedge clk);
    chk(req_ready, "R7 ready after response taken", {31'd0, req_ready}, 32'd1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule